// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block sequences a small microcontroller into and out of its low-power halt state. When the core issues a halt strobe, the controller gates off the system oscillator enable, raises the power-down flag and clears the time-out flag. It also records which interrupt request flags were already pending, because those flags may not end this halt. While halted, it watches four kinds of wake source: the external reset request, the watchdog overflow, newly raised interrupt request flags, and falling edges on port pins whose wake enable is set.

On a wake, the controller latches the winning cause and the action the core must take when it resumes. It switches the oscillator enable back on and holds the core stalled for a fixed settling period. At the end of the stall it gives a one-cycle resume strobe that carries the action:
- continue at the next instruction;
- enter the interrupt;
- warm-reset the program counter and stack pointer;
- fully initialize.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After reset the outputs read halted_o=0, stall_o=0, osc_en_o=1, pdf_o=0, to_o=0, cause_o=0, resume_valid_o=0.
- R2: A halt_i strobe while running gives, from the next cycle on, halted_o=1, osc_en_o=0, pdf_o=1 and to_o=0. A halt_i strobe while halted or stalled has no effect.
- R3: Every wake is followed by stall_o=1 for exactly STALL_CYCLES (default 1024) cycles with osc_en_o=1. The next cycle carries a single resume_valid_o pulse with resume_act_o valid, and the block is then running again.
- R4: A falling edge on a pin whose port_wake_en_i bit is 1 wakes the halted block with cause_o=4 and resume_act_o=0 (next instruction). stall_o rises at the third rising clock edge after the pin falls, because of two synchronizer stages and one edge register.
- R5: A falling edge on a pin whose wake enable is 0 does not wake the block, and neither does a rising edge on any pin.
- R6: An interrupt request flag that is already 1 when halt is entered cannot wake the block during that halt.
- R7: A newly raised interrupt request flag wakes the block with cause_o=3. resume_act_o=1 (take interrupt) when that flag's enable is 1 and stack_full_i=0; otherwise resume_act_o=0.
- R8: A watchdog overflow wakes the block with cause_o=2, sets to_o=1 and gives resume_act_o=2 (warm reset of program counter and stack pointer).
- R9: An external reset request while halted wakes the block with cause_o=1 and resume_act_o=3 (full initialization), and leaves to_o=0.
- R10: When wake sources coincide in one cycle, external reset beats watchdog overflow, which beats interrupt, which beats port edge.
- R11: pdf_o stays 1 through a wake. A clrwdt_i strobe while running clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| halt_i | input | 1 | Halt instruction strobe |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| port_i | input | NPIN | Asynchronous port pin levels |
| port_wake_en_i | input | NPIN | Per-pin wake enables |
| irq_flag_i | input | NIRQ | Interrupt request flags |
| irq_en_i | input | NIRQ | Interrupt enables |
| stack_full_i | input | 1 | Call stack is full |
| halted_o | output | 1 | Block is in the halt state |
| osc_en_o | output | 1 | System oscillator enable |
| stall_o | output | 1 | Core held in post-wake stall |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Time-out flag |
| cause_o | output | 3 | Latched wake cause: 0 none, 1 external, 2 watchdog, 3 interrupt, 4 port |
| resume_valid_o | output | 1 | One-cycle strobe when the stall ends |
| resume_act_o | output | 2 | Resume action: 0 next, 1 interrupt, 2 warm reset, 3 full init |

## Verification
The wake arbiter can see a port edge, a fresh interrupt and a watchdog overflow in the same cycle. The same holds for an external reset together with a watchdog overflow. The bench provokes the first case by dropping an enabled pin and waiting out the two synchronizer cycles. It then raises the interrupt flag and the overflow pulse just before the edge that also registers the pin edge. The scoreboard expects the higher-priority cause and its action at the resume strobe, and expects to_o to reflect only the winning source.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_STALL = 2'd2
  } pwk_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_EXT  = 3'd1,
    CAUSE_WDT  = 3'd2,
    CAUSE_IRQ  = 3'd3,
    CAUSE_PORT = 3'd4
  } pwk_cause_e;

  typedef enum logic [1:0] {
    ACT_NEXT = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_WARM = 2'd2,
    ACT_FULL = 2'd3
  } pwk_act_e;
endpackage

// File: rtl/pwk_pin_edge.sv
module pwk_pin_edge #(
  parameter int NPIN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] wake_en_i,
  input  logic            arm_i,
  output logic [NPIN-1:0] fall_o
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[TOP-1:0], pins_i[g]};
        prev_q <= sync_q[TOP];
      end
    end

    assign fall_o[g] = arm_i & wake_en_i[g] & prev_q & ~sync_q[TOP];
  end
endmodule

// File: rtl/pwk_wake_arb.sv
module pwk_wake_arb
  import pwk_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int NIRQ = 4
) (
  input  logic            ext_rst_i,
  input  logic            wdt_ovf_i,
  input  logic [NIRQ-1:0] irq_flag_i,
  input  logic [NIRQ-1:0] irq_blk_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            stack_full_i,
  input  logic [NPIN-1:0] port_fall_i,
  output logic            wake_o,
  output pwk_cause_e      cause_o,
  output pwk_act_e        act_o
);
  logic [NIRQ-1:0] fresh_irq;
  logic            irq_hit;
  logic            irq_take;
  logic            port_hit;

  assign fresh_irq = irq_flag_i & ~irq_blk_i;
  assign irq_hit   = |fresh_irq;
  assign irq_take  = (|(fresh_irq & irq_en_i)) & ~stack_full_i;
  assign port_hit  = |port_fall_i;

  always_comb begin
    wake_o  = 1'b1;
    cause_o = CAUSE_NONE;
    act_o   = ACT_NEXT;
    if (ext_rst_i) begin
      cause_o = CAUSE_EXT;
      act_o   = ACT_FULL;
    end else if (wdt_ovf_i) begin
      cause_o = CAUSE_WDT;
      act_o   = ACT_WARM;
    end else if (irq_hit) begin
      cause_o = CAUSE_IRQ;
      act_o   = irq_take ? ACT_IRQ : ACT_NEXT;
    end else if (port_hit) begin
      cause_o = CAUSE_PORT;
      act_o   = ACT_NEXT;
    end else begin
      wake_o  = 1'b0;
    end
  end
endmodule

// File: rtl/pwk_stall_cnt.sv
module pwk_stall_cnt #(
  parameter int STALL_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STALL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = run_i & (cnt_q == LAST);
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
  import pwk_pkg::*;
#(
  parameter int NPIN         = 8,
  parameter int NIRQ         = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_i,
  input  logic            clrwdt_i,
  input  logic            ext_rst_i,
  input  logic            wdt_ovf_i,
  input  logic [NPIN-1:0] port_i,
  input  logic [NPIN-1:0] port_wake_en_i,
  input  logic [NIRQ-1:0] irq_flag_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            stack_full_i,
  output logic            halted_o,
  output logic            osc_en_o,
  output logic            stall_o,
  output logic            pdf_o,
  output logic            to_o,
  output logic [2:0]      cause_o,
  output logic            resume_valid_o,
  output logic [1:0]      resume_act_o
);
  pwk_state_e      state_q;
  logic [NIRQ-1:0] irq_blk_q;
  logic [NPIN-1:0] port_fall;
  logic            wake;
  pwk_cause_e      wake_cause;
  pwk_act_e        wake_act;
  logic            stall_last;
  logic            in_halt;
  logic            in_stall;
  logic            osc_q, pdf_q, to_q, rv_q;
  pwk_cause_e      cause_q;
  pwk_act_e        act_q;

  assign in_halt  = (state_q == ST_HALT);
  assign in_stall = (state_q == ST_STALL);

  pwk_pin_edge #(
    .NPIN        (NPIN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (port_i),
    .wake_en_i (port_wake_en_i),
    .arm_i     (in_halt),
    .fall_o    (port_fall)
  );

  pwk_wake_arb #(
    .NPIN (NPIN),
    .NIRQ (NIRQ)
  ) u_arb (
    .ext_rst_i    (ext_rst_i),
    .wdt_ovf_i    (wdt_ovf_i),
    .irq_flag_i   (irq_flag_i),
    .irq_blk_i    (irq_blk_q),
    .irq_en_i     (irq_en_i),
    .stack_full_i (stack_full_i),
    .port_fall_i  (port_fall),
    .wake_o       (wake),
    .cause_o      (wake_cause),
    .act_o        (wake_act)
  );

  pwk_stall_cnt #(
    .STALL_CYCLES (STALL_CYCLES)
  ) u_stall (
    .clk     (clk),
    .rst     (rst),
    .start_i (in_halt & wake),
    .run_i   (in_stall),
    .last_o  (stall_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      irq_blk_q <= '0;
      osc_q     <= 1'b1;
      pdf_q     <= 1'b0;
      to_q      <= 1'b0;
      rv_q      <= 1'b0;
      cause_q   <= CAUSE_NONE;
      act_q     <= ACT_NEXT;
    end else begin
      rv_q <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (halt_i) begin
            state_q   <= ST_HALT;
            irq_blk_q <= irq_flag_i;
            osc_q     <= 1'b0;
            pdf_q     <= 1'b1;
            to_q      <= 1'b0;
          end else if (clrwdt_i) begin
            pdf_q <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake) begin
            state_q <= ST_STALL;
            osc_q   <= 1'b1;
            cause_q <= wake_cause;
            act_q   <= wake_act;
            if (wake_cause == CAUSE_WDT) to_q <= 1'b1;
          end
        end
        ST_STALL: begin
          if (stall_last) begin
            state_q <= ST_RUN;
            rv_q    <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign halted_o       = in_halt;
  assign stall_o        = in_stall;
  assign osc_en_o       = osc_q;
  assign pdf_o          = pdf_q;
  assign to_o           = to_q;
  assign cause_o        = cause_q;
  assign resume_valid_o = rv_q;
  assign resume_act_o   = act_q;
endmodule

// File: rtl/pwk_chk.sv
module pwk_chk #(
  parameter int STALL_CYCLES = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       halt_i,
  input logic       ext_rst_i,
  input logic       wdt_ovf_i,
  input logic       halted_o,
  input logic       osc_en_o,
  input logic       stall_o,
  input logic       pdf_o,
  input logic       to_o,
  input logic [2:0] cause_o,
  input logic       resume_valid_o
);
  logic [31:0] stall_cnt;

  always_ff @(posedge clk) begin
    if (rst || !stall_o) stall_cnt <= '0;
    else                 stall_cnt <= stall_cnt + 32'd1;
  end

  a_r2_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && !stall_o && halt_i) |=> (halted_o && pdf_o && !to_o && !osc_en_o));

  a_r2_osc_off: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !osc_en_o);

  a_r2_one_state: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halted_o, stall_o}));

  a_r3_stall_len: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> (stall_cnt == STALL_CYCLES));

  a_r3_resume_after_stall: assert property (@(posedge clk) disable iff (rst)
    resume_valid_o |-> ($past(stall_o) && !stall_o && osc_en_o));

  a_r8_wdt_wake: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !ext_rst_i && wdt_ovf_i) |=> (stall_o && to_o && cause_o == 3'd2));

  a_r9_ext_wake: assert property (@(posedge clk) disable iff (rst)
    (halted_o && ext_rst_i) |=> (stall_o && !to_o && cause_o == 3'd1));
endmodule

bind pwrdn_wake_ctrl pwk_chk #(.STALL_CYCLES(STALL_CYCLES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .halt_i         (halt_i),
  .ext_rst_i      (ext_rst_i),
  .wdt_ovf_i      (wdt_ovf_i),
  .halted_o       (halted_o),
  .osc_en_o       (osc_en_o),
  .stall_o        (stall_o),
  .pdf_o          (pdf_o),
  .to_o           (to_o),
  .cause_o        (cause_o),
  .resume_valid_o (resume_valid_o)
);

// File: tb/pwrdn_wake_ctrl_tb.sv
module pwrdn_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 8;
  localparam int NIRQ = 4;
  localparam int STALL = 1024;

  typedef struct packed {
    logic [2:0] cause;
    logic [1:0] act;
    logic       to;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 0, clrwdt_i = 0, ext_rst_i = 0, wdt_ovf_i = 0, stack_full_i = 0;
  logic [NPIN-1:0] port_i = '1, port_wake_en_i = 8'b0000_0101;
  logic [NIRQ-1:0] irq_flag_i = '0, irq_en_i = '0;
  logic halted_o, osc_en_o, stall_o, pdf_o, to_o, resume_valid_o;
  logic [2:0] cause_o;
  logic [1:0] resume_act_o;

  int checks = 0;
  int errors = 0;
  int resumes = 0;
  int stall_seen = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_wake_ctrl #(.NPIN(NPIN), .NIRQ(NIRQ), .STALL_CYCLES(STALL)) u_dut (
    .clk(clk), .rst(rst), .halt_i(halt_i), .clrwdt_i(clrwdt_i),
    .ext_rst_i(ext_rst_i), .wdt_ovf_i(wdt_ovf_i), .port_i(port_i),
    .port_wake_en_i(port_wake_en_i), .irq_flag_i(irq_flag_i),
    .irq_en_i(irq_en_i), .stack_full_i(stack_full_i), .halted_o(halted_o),
    .osc_en_o(osc_en_o), .stall_o(stall_o), .pdf_o(pdf_o), .to_o(to_o),
    .cause_o(cause_o), .resume_valid_o(resume_valid_o), .resume_act_o(resume_act_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [2:0] c, input logic [1:0] a, input logic t);
    exp_t e;
    e.cause = c; e.act = a; e.to = t;
    sb_q.push_back(e);
  endtask

  // Monitor: stall length and scoreboard comparison at each resume strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_o) stall_seen++;
      if (resume_valid_o) begin
        chk(stall_seen == STALL, "R3 stall length", stall_seen, STALL);
        chk(osc_en_o == 1'b1, "R3 osc on at resume", int'(osc_en_o), 1);
        stall_seen = 0;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected resume", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cause_o == e.cause, "R4/R7/R8/R9/R10 cause", int'(cause_o), int'(e.cause));
          chk(resume_act_o == e.act, "R4/R7/R8/R9/R10 action", int'(resume_act_o), int'(e.act));
          chk(to_o == e.to, "R8/R9 time-out flag", int'(to_o), int'(e.to));
        end
        resumes++;
      end
    end
  end

  task automatic wait_resume();
    int start;
    start = resumes;
    while (resumes == start) @(negedge clk);
    tick(1);
    chk(!halted_o && !stall_o && !resume_valid_o, "R3 running after resume",
        int'({halted_o, stall_o, resume_valid_o}), 0);
  endtask

  task automatic enter_halt();
    halt_i = 1'b1;
    tick(1);
    halt_i = 1'b0;
    chk(halted_o && !osc_en_o && pdf_o && !to_o, "R2 halt entry",
        int'({halted_o, osc_en_o, pdf_o, to_o}), 4'b1010);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk(!halted_o && !stall_o && osc_en_o && !pdf_o && !to_o && cause_o == 0 && !resume_valid_o,
        "R1 reset state", int'({halted_o, stall_o, osc_en_o, pdf_o, to_o, cause_o, resume_valid_o}),
        9'b001000000);

    // R4: enabled pin falling edge, latency of three edges
    enter_halt();
    push(3'd4, 2'd0, 1'b0);
    port_i[0] = 1'b0;
    tick(2);
    chk(halted_o && !stall_o, "R4 no wake before third edge", int'(stall_o), 0);
    tick(1);
    chk(stall_o && osc_en_o, "R4 stall at third edge", int'({stall_o, osc_en_o}), 3);
    // R2: halt strobe during stall has no effect
    halt_i = 1'b1; tick(1); halt_i = 1'b0;
    wait_resume();
    port_i[0] = 1'b1;
    chk(pdf_o == 1'b1, "R11 pdf kept through wake", int'(pdf_o), 1);

    // R5: disabled pin fall and enabled pin rise do not wake; then R8 watchdog
    port_i[2] = 1'b0;
    tick(4);
    enter_halt();
    port_i[1] = 1'b0;
    port_i[2] = 1'b1;
    tick(10);
    chk(halted_o && !stall_o, "R5 ignored pin edges", int'({halted_o, stall_o}), 2);
    push(3'd2, 2'd2, 1'b1);
    wdt_ovf_i = 1'b1; tick(1); wdt_ovf_i = 1'b0;
    chk(stall_o && to_o, "R8 watchdog wake sets to", int'({stall_o, to_o}), 3);
    wait_resume();
    port_i[1] = 1'b1;
    tick(4);

    // R6: pending flag blocked, then R7 fresh enabled irq taken
    irq_flag_i[0] = 1'b1; irq_en_i = 4'b0011;
    enter_halt();
    tick(10);
    chk(halted_o && !stall_o, "R6 pending irq blocked", int'({halted_o, stall_o}), 2);
    push(3'd3, 2'd1, 1'b0);
    irq_flag_i[1] = 1'b1;
    wait_resume();
    irq_flag_i = '0;

    // R7: disabled interrupt resumes inline
    enter_halt();
    push(3'd3, 2'd0, 1'b0);
    irq_flag_i[2] = 1'b1;
    wait_resume();
    irq_flag_i = '0;

    // R7: enabled interrupt with full stack resumes inline
    stack_full_i = 1'b1;
    enter_halt();
    push(3'd3, 2'd0, 1'b0);
    irq_flag_i[1] = 1'b1;
    wait_resume();
    irq_flag_i = '0; stack_full_i = 1'b0;

    // R9: external reset
    enter_halt();
    push(3'd1, 2'd3, 1'b0);
    ext_rst_i = 1'b1; tick(1); ext_rst_i = 1'b0;
    wait_resume();

    // R10: port edge, interrupt and watchdog in one cycle -> watchdog
    irq_en_i = 4'b1000;
    enter_halt();
    push(3'd2, 2'd2, 1'b1);
    port_i[0] = 1'b0;
    tick(2);
    irq_flag_i[3] = 1'b1; wdt_ovf_i = 1'b1;
    tick(1);
    wdt_ovf_i = 1'b0;
    wait_resume();
    irq_flag_i = '0; port_i[0] = 1'b1;
    tick(4);

    // R10: external reset beats watchdog
    enter_halt();
    push(3'd1, 2'd3, 1'b0);
    ext_rst_i = 1'b1; wdt_ovf_i = 1'b1; tick(1);
    ext_rst_i = 1'b0; wdt_ovf_i = 1'b0;
    wait_resume();

    // R10: interrupt beats port edge
    enter_halt();
    push(3'd3, 2'd1, 1'b0);
    port_i[0] = 1'b0;
    tick(2);
    irq_flag_i[3] = 1'b1;
    wait_resume();
    irq_flag_i = '0; port_i[0] = 1'b1;
    tick(4);

    // R11: clear-watchdog strobe clears pdf
    chk(pdf_o == 1'b1, "R11 pdf set before clear", int'(pdf_o), 1);
    clrwdt_i = 1'b1; tick(1); clrwdt_i = 1'b0;
    chk(pdf_o == 1'b0, "R11 pdf cleared", int'(pdf_o), 0);

    chk(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule